// File: doc/BRIEF.md
# Debounced Power-Down Request Generator

This block watches two general-purpose input pins from a device on a local bus and tells the host when that device has gone quiet. Each pin has an enable bit and a polarity bit. The polarity bit names the level at which the pin would raise the device's interrupt. A pin counts as idle when it sits at the opposite level. When every enabled pin is idle, the block can request a power-down.

Before the request is raised, a stability filter requires the idle condition to hold for a selectable number of clock cycles. Any return to the interrupting level restarts the count. The pins are asynchronous, so each one first passes through a two-flop synchroniser. The request is a registered level. It falls when software pulses the clear input. It also falls when the pins stop being idle.

A clear consumes the current idle episode. The request comes back only after the pins have left the idle state and then qualified again.

Top module: `pdreq_gen`

## Requirements
- R1: With both enable bits at 0, `pd_req` never asserts, whatever the pin levels.
- R2: An enabled pin is idle when its synchronised level differs from its polarity bit (polarity 1 = high level raises the interrupt, polarity 0 = low level raises it). An enabled pin at its interrupt level blocks the request.
- R3: A pin whose enable bit is 0 has no effect. Toggling it leaves `pd_req` unchanged.
- R4: With both pins enabled, the request needs both pins to be idle.
- R5: With `filt_sel` = 0, `pd_req` rises on the third rising clock edge after the pins become idle (two synchroniser stages plus the output register).
- R6: `filt_sel` values 1, 2 and 3 select stability periods of 16, 256 and 4096 cycles. `pd_req` rises on edge 3+P after the pins become idle.
- R7: A departure from the idle state during the stability window, even for one cycle, restarts the count. The full period is then counted again from the return to idle.
- R8: When the pins leave the idle state, `pd_req` falls on the third rising edge after the change.
- R9: A one-cycle `req_clr` pulse drops `pd_req` on the next edge. `pd_req` stays low until the pins have left idle and then qualified again.
- R10: Synchronous reset (`rst` = 1) clears `pd_req`, the synchronisers and the filter count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 2 | Asynchronous general-purpose pins |
| pin_en | input | 2 | Per-pin enable for the power-down function |
| irq_pol | input | 2 | Per-pin level that raises the interrupt |
| filt_sel | input | 2 | Stability period: 0, 16, 256 or 4096 cycles |
| req_clr | input | 1 | One-cycle clear of the request |
| pd_req | output | 1 | Registered power-down request |

## Verification
The tests cover each filter select and measure the exact rising edge, which separates a correct period from an off-by-one count or a wrong select decode. A one-cycle glitch inside the window separates a restarting filter from one that only pauses or ignores short glitches. The tests also use mixed idle and busy pins with one or both enables, and both polarities. These show whether the busy level is inverted correctly and whether a disabled pin is masked. A clear followed by a held idle level shows that a clear lasts until the pins leave idle, and is not undone once the count has qualified again.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int NPIN = 2;
  localparam int SEL_W = 2;

  // Stability period for a select code; code 0 means no filtering
  function automatic int unsigned period_of(input logic [SEL_W-1:0] sel,
                                            input int unsigned lg1,
                                            input int unsigned lg2,
                                            input int unsigned lg3);
    case (sel)
      2'd1: return 32'd1 << lg1;
      2'd2: return 32'd1 << lg2;
      2'd3: return 32'd1 << lg3;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/pdr_sync.sv
module pdr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdr_idle.sv
module pdr_idle #(
  parameter int W = 2
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] pol,
  output logic         all_idle
);
  logic [W-1:0] ok;

  // A disabled pin never blocks; an enabled pin is fine when away from its interrupt level
  for (genvar g = 0; g < W; g++) begin : g_pin
    assign ok[g] = ~en[g] | (lvl[g] ^ pol[g]);
  end

  assign all_idle = (|en) & (&ok);
endmodule

// File: rtl/pdr_filter.sv
module pdr_filter #(
  parameter int LOG_P1 = 4,
  parameter int LOG_P2 = 8,
  parameter int LOG_P3 = 12,
  localparam int CW = LOG_P3 + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       all_idle,
  input  logic [1:0] sel,
  output logic       stable
);
  import pdr_pkg::*;

  localparam logic [CW-1:0] CMAX = CW'(1) << LOG_P3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] need;

  always_comb begin
    need = CW'(period_of(sel, LOG_P1, LOG_P2, LOG_P3));
  end

  // Any break of the idle condition restarts the count; saturates at the longest period
  always_ff @(posedge clk) begin
    if (rst || !all_idle) cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign stable = all_idle && (cnt >= need);
endmodule

// File: rtl/pdreq_gen.sv
module pdreq_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int LOG_P1 = 4,
  parameter int LOG_P2 = 8,
  parameter int LOG_P3 = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pin_in,
  input  logic [1:0] pin_en,
  input  logic [1:0] irq_pol,
  input  logic [1:0] filt_sel,
  input  logic       req_clr,
  output logic       pd_req
);
  import pdr_pkg::*;

  logic [NPIN-1:0] pin_s;
  logic            all_idle;
  logic            stable;
  logic            consumed;

  pdr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  pdr_idle #(.W(NPIN)) u_idle (
    .lvl(pin_s), .en(pin_en), .pol(irq_pol), .all_idle(all_idle)
  );

  pdr_filter #(.LOG_P1(LOG_P1), .LOG_P2(LOG_P2), .LOG_P3(LOG_P3)) u_filt (
    .clk(clk), .rst(rst), .all_idle(all_idle), .sel(filt_sel), .stable(stable)
  );

  // A clear consumes the current idle episode until the pins leave idle
  always_ff @(posedge clk) begin
    if (rst || !all_idle) consumed <= 1'b0;
    else if (req_clr) consumed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pd_req <= 1'b0;
    else pd_req <= stable && !consumed && !req_clr;
  end
endmodule

// File: rtl/pdreq_gen_chk.sv
module pdreq_gen_chk #(
  parameter int LOG_P1 = 4,
  parameter int LOG_P2 = 8,
  parameter int LOG_P3 = 12,
  localparam int CW = LOG_P3 + 1
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pin_en,
  input logic [1:0] filt_sel,
  input logic       req_clr,
  input logic       all_idle,
  input logic       pd_req
);
  import pdr_pkg::*;

  logic [CW-1:0] run;
  logic [CW-1:0] need;

  always_comb need = CW'(period_of(filt_sel, LOG_P1, LOG_P2, LOG_P3));

  always_ff @(posedge clk) begin
    if (rst || !all_idle) run <= '0;
    else if (run != (CW'(1) << LOG_P3)) run <= run + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !pd_req); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) pin_en == 2'b00 |=> !pd_req); // R1
  AST_RISE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(pd_req) |-> $past(all_idle)); // R4
  AST_RISE_AFTER_PERIOD: assert property (@(posedge clk) disable iff (rst) $rose(pd_req) |-> $past(run) >= $past(need)); // R6
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst) !all_idle |=> !pd_req); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst) req_clr |=> !pd_req); // R9
endmodule

bind pdreq_gen pdreq_gen_chk #(.LOG_P1(LOG_P1), .LOG_P2(LOG_P2), .LOG_P3(LOG_P3)) u_chk (
  .clk(clk), .rst(rst), .pin_en(pin_en), .filt_sel(filt_sel),
  .req_clr(req_clr), .all_idle(all_idle), .pd_req(pd_req)
);

// File: tb/sim_pdreq_gen.sv
`timescale 1ns/1ps
module sim_pdreq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pin_in = 2'b00;
  logic [1:0] pin_en = 2'b00;
  logic [1:0] irq_pol = 2'b00;
  logic [1:0] filt_sel = 2'b00;
  logic       req_clr = 1'b0;
  logic       pd_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pdreq_gen u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_en(pin_en), .irq_pol(irq_pol),
    .filt_sel(filt_sel), .req_clr(req_clr), .pd_req(pd_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pd_req=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Polarity 0: low level raises the interrupt, so high is idle
  task automatic go_busy();
    pin_in = 2'b00; irq_pol = 2'b00;
    wait_n(6);
  endtask

  task automatic t_reset();
    rst = 1'b1; wait_n(3);
    chk("R10 reset state", pd_req, 1'b0);
    rst = 1'b0; wait_n(1);
    pin_en = 2'b01; filt_sel = 2'd0; pin_in = 2'b01;
    wait_n(5);
    chk("R10 pre-reset request", pd_req, 1'b1);
    rst = 1'b1; wait_n(1);
    chk("R10 reset drops request", pd_req, 1'b0);
    rst = 1'b0; pin_in = 2'b00; wait_n(5);
  endtask

  task automatic t_disabled();
    pin_en = 2'b00; filt_sel = 2'd0;
    go_busy();
    pin_in = 2'b11; wait_n(20);
    chk("R1 both disabled, pins high", pd_req, 1'b0);
    pin_in = 2'b10; wait_n(10);
    chk("R1 both disabled, mixed pins", pd_req, 1'b0);
  endtask

  task automatic t_period(input logic [1:0] sel, input int p);
    string tg;
    tg = (sel == 2'd0) ? "R5" : "R6";
    pin_en = 2'b01; filt_sel = sel;
    go_busy();
    pin_in = 2'b01;
    wait_n(p + 2);
    chk({tg, " one edge before rise"}, pd_req, 1'b0);
    wait_n(1);
    chk({tg, " rise edge"}, pd_req, 1'b1);
    wait_n(1);
    chk({tg, " held"}, pd_req, 1'b1);
  endtask

  task automatic t_polarity();
    pin_en = 2'b01; filt_sel = 2'd0;
    go_busy();
    wait_n(15);
    chk("R2 pin at interrupt level (low, pol 0)", pd_req, 1'b0);
    pin_in = 2'b01; wait_n(3);
    chk("R2 pin idle (high, pol 0)", pd_req, 1'b1);
    irq_pol = 2'b01; wait_n(2);
    chk("R2 pol 1 makes high busy", pd_req, 1'b0);
    pin_in = 2'b00; wait_n(4);
    chk("R2 pol 1, low is idle", pd_req, 1'b1);
    irq_pol = 2'b00;
  endtask

  task automatic t_masked();
    pin_en = 2'b01; filt_sel = 2'd0;
    go_busy();
    pin_in = 2'b01; wait_n(3);
    chk("R3 request with pin0 only", pd_req, 1'b1);
    for (int i = 0; i < 6; i++) begin
      pin_in[1] = ~pin_in[1];
      wait_n(1);
      chk("R3 disabled pin1 toggling", pd_req, 1'b1);
    end
  endtask

  task automatic t_both();
    pin_en = 2'b11; filt_sel = 2'd0;
    go_busy();
    pin_in = 2'b01; wait_n(10);
    chk("R4 pin1 still busy", pd_req, 1'b0);
    pin_in = 2'b10; wait_n(10);
    chk("R4 pin0 still busy", pd_req, 1'b0);
    pin_in = 2'b11; wait_n(3);
    chk("R4 both idle", pd_req, 1'b1);
  endtask

  task automatic t_restart();
    pin_en = 2'b01; filt_sel = 2'd1;
    go_busy();
    pin_in = 2'b01; wait_n(10);
    pin_in = 2'b00; wait_n(1);
    pin_in = 2'b01;
    wait_n(18);
    chk("R7 glitch restarts count (before)", pd_req, 1'b0);
    wait_n(1);
    chk("R7 full period after glitch", pd_req, 1'b1);
  endtask

  task automatic t_leave();
    pin_en = 2'b01; filt_sel = 2'd0;
    go_busy();
    pin_in = 2'b01; wait_n(4);
    pin_in = 2'b00; wait_n(2);
    chk("R8 still high two edges after busy", pd_req, 1'b1);
    wait_n(1);
    chk("R8 drops on third edge", pd_req, 1'b0);
  endtask

  task automatic t_clear();
    pin_en = 2'b01; filt_sel = 2'd0;
    go_busy();
    pin_in = 2'b01; wait_n(4);
    chk("R9 request before clear", pd_req, 1'b1);
    req_clr = 1'b1; wait_n(1);
    req_clr = 1'b0;
    chk("R9 drops after clear", pd_req, 1'b0);
    wait_n(12);
    chk("R9 stays low while idle held", pd_req, 1'b0);
    pin_in = 2'b00; wait_n(5);
    pin_in = 2'b01; wait_n(3);
    chk("R9 new idle episode re-raises", pd_req, 1'b1);
  endtask

  initial begin
    wait_n(1);
    t_reset();
    t_disabled();
    t_polarity();
    t_period(2'd0, 0);
    t_period(2'd1, 16);
    t_period(2'd2, 256);
    t_period(2'd3, 4096);
    t_masked();
    t_both();
    t_restart();
    t_leave();
    t_clear();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end
endmodule